// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash device. Once a program or erase operation has been launched, it decides when that operation is over. It does this by reading the device status word again and again over a simple request/acknowledge read port. A start pulse latches the status address and begins polling. The block then reports, for each 16-bit byte lane, whether the operation finished or failed. A single completion or failure pulse closes the run.

The rule is the same for every lane. Two back-to-back reads form a pair, and the toggle bit is compared between them:

- If the toggle bit held steady, the lane is finished.
- If it moved and the time-limit flag is low, another pair is read.
- If it moved and the flag is high, one more pair is read as a re-check. This catches an operation that completed just as the flag rose. If the toggle bit still moves during the re-check, the lane has failed.

On any failure the block writes a reset command to the status address, which returns the device to array-read mode. A host may abandon polling and start again later; every new start discards what earlier reads left behind. A limit on the number of read pairs ends a run that never settles. That case also writes the reset command and raises a separate timeout pulse.

Top module: `toggle_poll_top`

## Requirements
- R1: After reset the block is idle: busy_o, req_o, done_o, fail_o and timeout_o are all low.
- R2: A start_i pulse while idle raises busy_o on the next cycle and latches stat_addr_i. Every transfer of the run uses that address, and req_o holds with stable address and direction until ack_i. While busy, start_i and stat_addr_i are ignored.
- R3: Each lane occupies 16 bits (lane l is bits 16l+15..16l), and its toggle bit is bit 6 of the lane. A lane whose toggle bit is equal in the two reads of a pair is marked done.
- R4: If a lane's toggle bit differs across the pair and its time-limit flag (bit 5 of the lane, taken from the second read of the pair) is low, another read pair follows. Completed runs therefore always use an even number of reads.
- R5: If the toggle bit differs and the flag is high, the next pair is a re-check. An unchanged toggle bit in the re-check marks the lane done.
- R6: A toggle bit that still differs in the re-check marks the lane failed. The block then issues one write of RST_CMD (we_o high) to the status address, and pulses fail_o in the cycle after that write is acknowledged.
- R7: Lanes are judged independently, and a lane that is already decided ignores later reads. done_o requires every lane done. Any failed lane ends the run as a failure after the current pair. lane_done_o and lane_fail_o hold the per-lane results until the next start.
- R8: done_o and fail_o are one-cycle pulses and never occur together. A pulse rises in the cycle after the final acknowledge, in the same cycle that busy_o falls.
- R9: Asserting abort_i while reading ends the run at the acknowledge of the outstanding read, with no pulse and no write. The next start begins again from a fresh read pair.
- R10: If MAX_PAIRS pairs complete with some lane undecided, the reset command is written, and timeout_o pulses together with fail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (taken only when idle) |
| abort_i | input | 1 | Abandon the current poll |
| stat_addr_i | input | ADDR_W | Status word address, latched at start |
| req_o | output | 1 | Transfer request |
| we_o | output | 1 | Transfer is a write (reset command) |
| addr_o | output | ADDR_W | Transfer address |
| wdata_o | output | DATA_W | Write data |
| ack_i | input | 1 | Transfer acknowledge |
| rdata_i | input | DATA_W | Read data, valid with ack_i |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | All lanes complete (pulse) |
| fail_o | output | 1 | Failure or timeout (pulse) |
| timeout_o | output | 1 | Pair limit reached (pulse with fail_o) |
| lane_done_o | output | LANES | Per-lane completed |
| lane_fail_o | output | LANES | Per-lane failed |

## Verification
busy_o is due one cycle after start_i. done_o is due one cycle after the acknowledge of the second read in the deciding pair. fail_o and timeout_o are due one cycle after the acknowledge of the reset-command write. The bench therefore drives and samples only on falling edges, and waits for the pulse before checking anything else. At the pulse it checks the read and write counts seen by its responder against an arithmetic model of the pair rule, and confirms that busy_o fell in that same cycle. One falling edge later it confirms the pulse has cleared. The sweep covers every combination of per-lane toggle-stop position and flag-rise position in a four-pair configuration.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;
  typedef enum logic [1:0] {LN_POLL, LN_RECHK, LN_DONE, LN_FAIL} lane_st_e;
  typedef enum logic [1:0] {S_IDLE, S_RD_A, S_RD_B, S_WR_RST} ctl_st_e;
endpackage

// File: rtl/toggle_lane_eval.sv
module toggle_lane_eval
  import toggle_poll_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     eval_i,
  input  logic     tog_a_i,
  input  logic     tog_b_i,
  input  logic     limit_i,
  output lane_st_e st_o,
  output lane_st_e nxt_o
);
  lane_st_e st_q, st_d;
  logic toggled;

  assign toggled = tog_a_i ^ tog_b_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      LN_POLL: begin
        if (!toggled)    st_d = LN_DONE;
        else if (limit_i) st_d = LN_RECHK;
      end
      LN_RECHK: st_d = toggled ? LN_FAIL : LN_DONE;
      default: st_d = st_q; // decided lanes hold
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= LN_POLL;
    else if (clear_i) st_q <= LN_POLL;
    else if (eval_i)  st_q <= st_d;
  end

  assign st_o  = st_q;
  assign nxt_o = st_d;
endmodule

// File: rtl/toggle_pair_cnt.sv
module toggle_pair_cnt #(
  parameter int MAX_PAIRS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (MAX_PAIRS < 2) ? 1 : $clog2(MAX_PAIRS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_PAIRS - 1));
endmodule

// File: rtl/toggle_poll_fsm.sv
module toggle_poll_fsm
  import toggle_poll_pkg::*;
#(
  parameter int              ADDR_W  = 20,
  parameter int              DATA_W  = 32,
  parameter logic [DATA_W-1:0] RST_CMD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] stat_addr_i,
  input  logic              ack_i,
  input  logic              all_done_i,
  input  logic              any_fail_i,
  input  logic              last_pair_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              clear_o,
  output logic              cap_o,
  output logic              eval_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o
);
  ctl_st_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic abort_q, abort_now, reading;
  logic tmo_q, tmo_arm;
  logic done_set, fail_set;
  logic done_q, fail_q, tmo_p_q;

  assign reading   = (st_q == S_RD_A) || (st_q == S_RD_B);
  assign abort_now = abort_i | abort_q;

  always_comb begin
    st_d     = st_q;
    clear_o  = 1'b0;
    cap_o    = 1'b0;
    eval_o   = 1'b0;
    done_set = 1'b0;
    fail_set = 1'b0;
    tmo_arm  = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = S_RD_A;
        clear_o = 1'b1;
      end
      S_RD_A: if (ack_i) begin
        if (abort_now) st_d = S_IDLE;
        else begin
          cap_o = 1'b1;
          st_d  = S_RD_B;
        end
      end
      S_RD_B: if (ack_i) begin
        if (abort_now) st_d = S_IDLE;
        else begin
          eval_o = 1'b1;
          if (any_fail_i) st_d = S_WR_RST;
          else if (all_done_i) begin
            st_d     = S_IDLE;
            done_set = 1'b1;
          end else if (last_pair_i) begin
            st_d    = S_WR_RST;
            tmo_arm = 1'b1;
          end else st_d = S_RD_A;
        end
      end
      S_WR_RST: if (ack_i) begin
        st_d     = S_IDLE;
        fail_set = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      abort_q <= 1'b0;
      tmo_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_p_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= reading && abort_now && !ack_i; // deferred to the pending ack
      done_q  <= done_set;
      fail_q  <= fail_set;
      tmo_p_q <= fail_set && tmo_q;
      if (clear_o) addr_q <= stat_addr_i;
      if (clear_o)      tmo_q <= 1'b0;
      else if (tmo_arm) tmo_q <= 1'b1;
    end
  end

  assign req_o     = (st_q != S_IDLE);
  assign we_o      = (st_q == S_WR_RST);
  assign addr_o    = addr_q;
  assign wdata_o   = we_o ? RST_CMD : '0;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_p_q;
endmodule

// File: rtl/toggle_poll_top.sv
module toggle_poll_top
  import toggle_poll_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 32,
  parameter int                LANE_W    = 16,
  parameter int                TOG_BIT   = 6,
  parameter int                LIM_BIT   = 5,
  parameter int                MAX_PAIRS = 4096,
  parameter logic [DATA_W-1:0] RST_CMD   = 'h00F0_00F0,
  localparam int               LANES     = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] stat_addr_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic [LANES-1:0]  lane_done_o,
  output logic [LANES-1:0]  lane_fail_o
);
  logic clear, cap, eval, last_pair;
  logic [LANES-1:0] first_tog_q;
  logic [LANES-1:0] nxt_done, nxt_fail;
  logic unused_rdata;

  assign unused_rdata = ^rdata_i;

  // only the toggle bit of the first read is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      first_tog_q <= '0;
    else if (clear)   first_tog_q <= '0;
    else if (cap) begin
      for (int l = 0; l < LANES; l++) first_tog_q[l] <= rdata_i[l*LANE_W + TOG_BIT];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_st_e st, nxt;
    toggle_lane_eval u_eval (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .eval_i  (eval),
      .tog_a_i (first_tog_q[l]),
      .tog_b_i (rdata_i[l*LANE_W + TOG_BIT]),
      .limit_i (rdata_i[l*LANE_W + LIM_BIT]),
      .st_o    (st),
      .nxt_o   (nxt)
    );
    assign nxt_done[l]    = (nxt == LN_DONE);
    assign nxt_fail[l]    = (nxt == LN_FAIL);
    assign lane_done_o[l] = (st == LN_DONE);
    assign lane_fail_o[l] = (st == LN_FAIL);
  end

  toggle_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (eval),
    .last_o  (last_pair)
  );

  toggle_poll_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RST_CMD (RST_CMD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .stat_addr_i (stat_addr_i),
    .ack_i       (ack_i),
    .all_done_i  (&nxt_done),
    .any_fail_i  (|nxt_fail),
    .last_pair_i (last_pair),
    .req_o       (req_o),
    .we_o        (we_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .clear_o     (clear),
    .cap_o       (cap),
    .eval_o      (eval),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .timeout_o   (timeout_o)
  );
endmodule

// File: rtl/toggle_poll_chk.sv
module toggle_poll_chk #(
  parameter int                ADDR_W  = 20,
  parameter int                DATA_W  = 32,
  parameter int                LANES   = 2,
  parameter logic [DATA_W-1:0] RST_CMD = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              req_o,
  input logic              we_o,
  input logic              ack_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              timeout_o,
  input logic [LANES-1:0]  lane_done_o
);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o)));
  p_done_after_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_o && !we_o && ack_i));
  p_rst_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> (wdata_o == RST_CMD));
  p_fail_after_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(req_o && we_o && ack_i));
  p_done_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&lane_done_o));
  p_pulse_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  p_busy_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> (!busy_o && $past(busy_o)));
  p_timeout_fail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o);
endmodule

bind toggle_poll_top toggle_poll_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .LANES   (LANES),
  .RST_CMD (RST_CMD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .req_o       (req_o),
  .we_o        (we_o),
  .ack_i       (ack_i),
  .addr_o      (addr_o),
  .wdata_o     (wdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .timeout_o   (timeout_o),
  .lane_done_o (lane_done_o)
);

// File: tb/toggle_poll_top_tb_top.sv
module toggle_poll_top_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          MAXP = 4;
  localparam int          AW   = 20;
  localparam logic [31:0] RCMD = 32'h00F0_00F0;

  logic clk_i = 1'b0;
  logic rst_ni, start_i, abort_i, ack_i;
  logic [AW-1:0] stat_addr_i;
  logic [31:0] rdata_i;
  logic req_o, we_o, busy_o, done_o, fail_o, timeout_o;
  logic [AW-1:0] addr_o;
  logic [31:0] wdata_o;
  logic [1:0] lane_done_o, lane_fail_o;

  int n_checks = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, bad_addr = 0;
  logic [31:0] wr_data;
  logic [AW-1:0] exp_addr;
  int tv[2], fv[2];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  toggle_poll_top #(.ADDR_W(AW), .MAX_PAIRS(MAXP), .RST_CMD(RCMD)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .stat_addr_i(stat_addr_i), .req_o(req_o), .we_o(we_o), .addr_o(addr_o),
    .wdata_o(wdata_o), .ack_i(ack_i), .rdata_i(rdata_i), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o),
    .lane_done_o(lane_done_o), .lane_fail_o(lane_fail_o)
  );

  // toggle bit: alternates until read t, holds for two reads, then alternates again
  function automatic logic tbit(int t, int r);
    if (r < t) return r[0];
    if (r < t + 2) return t[0];
    return r[0];
  endfunction

  function automatic logic [31:0] mk_word(int r);
    logic [31:0] w;
    for (int l = 0; l < 2; l++) begin
      logic [15:0] h;
      h = 16'(r * 4951 + l * 9323 + 23130);
      h[6] = tbit(tv[l], r);
      h[5] = (r >= fv[l]);
      w[l*16 +: 16] = h;
    end
    return w;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(output int reads, output int d, output int f, output int t,
                       output int ld, output int lf);
    int st[2];
    int pairs;
    st[0] = 0; st[1] = 0; pairs = 0; d = 0; f = 0; t = 0;
    while (1) begin
      for (int l = 0; l < 2; l++) begin
        if (st[l] < 2) begin
          logic tg, fl;
          tg = tbit(tv[l], 2*pairs) != tbit(tv[l], 2*pairs + 1);
          fl = (2*pairs + 1 >= fv[l]);
          if (st[l] == 0) begin
            if (!tg) st[l] = 2;
            else if (fl) st[l] = 1;
          end else st[l] = tg ? 3 : 2;
        end
      end
      pairs++;
      if (st[0] == 3 || st[1] == 3) begin f = 1; break; end
      if (st[0] == 2 && st[1] == 2) begin d = 1; break; end
      if (pairs == MAXP) begin f = 1; t = 1; break; end
    end
    reads = 2 * pairs;
    ld = ((st[0] == 2) ? 1 : 0) + ((st[1] == 2) ? 2 : 0);
    lf = ((st[0] == 3) ? 1 : 0) + ((st[1] == 3) ? 2 : 0);
  endtask

  // responder: one idle cycle between transfers
  initial begin
    ack_i = 1'b0;
    rdata_i = '0;
    wr_data = '0;
    forever begin
      @(negedge clk_i);
      if (ack_i) ack_i = 1'b0;
      else if (req_o) begin
        if (addr_o != exp_addr) bad_addr++;
        if (we_o) begin
          wr_cnt++;
          wr_data = wdata_o;
        end else begin
          rdata_i = mk_word(rd_cnt);
          rd_cnt++;
        end
        ack_i = 1'b1;
      end
    end
  end

  task automatic run_case(int t0, int f0, int t1, int f1, bit poke);
    int er, ed, ef, et, eld, elf;
    int cyc;
    bit got;
    tv[0] = t0; fv[0] = f0; tv[1] = t1; fv[1] = f1;
    rd_cnt = 0; wr_cnt = 0; bad_addr = 0;
    exp_addr = AW'(t0 * 7 + t1 * 3 + f0 + f1 * 5 + 1);
    model(er, ed, ef, et, eld, elf);
    @(negedge clk_i);
    stat_addr_i = exp_addr;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check_eq("R2", "busy after start", int'(busy_o), 1);
    got = 1'b0;
    cyc = 0;
    while (!got && cyc < 200) begin
      @(negedge clk_i);
      cyc++;
      if (poke && cyc == 4) begin
        start_i = 1'b1;
        stat_addr_i = ~exp_addr;
      end else start_i = 1'b0;
      if (done_o || fail_o) got = 1'b1;
    end
    start_i = 1'b0;
    check_eq("R8", "busy low at pulse", int'(busy_o), 0);
    check_eq("R3 R5", "done pulse", int'(done_o), ed);
    check_eq("R5 R6", "fail pulse", int'(fail_o), ef);
    check_eq("R10", "timeout pulse", int'(timeout_o), et);
    check_eq("R4", "read count", rd_cnt, er);
    check_eq("R6", "reset writes", wr_cnt, ef);
    if (ef != 0) check_eq("R6", "reset data", int'(wr_data), int'(RCMD));
    check_eq("R2", "address mismatches", bad_addr, 0);
    check_eq("R7", "lane done", int'(lane_done_o), eld);
    check_eq("R7", "lane fail", int'(lane_fail_o), elf);
    @(negedge clk_i);
    check_eq("R8", "pulse width", int'(done_o || fail_o), 0);
  endtask

  task automatic abort_case();
    int seen;
    tv[0] = 99; fv[0] = 99; tv[1] = 99; fv[1] = 99;
    rd_cnt = 0; wr_cnt = 0; bad_addr = 0;
    exp_addr = AW'(20'h00abc);
    @(negedge clk_i);
    stat_addr_i = exp_addr;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (rd_cnt < 3) @(negedge clk_i);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (done_o || fail_o) seen++;
    end
    check_eq("R9", "busy after abort", int'(busy_o), 0);
    check_eq("R9", "pulses after abort", seen, 0);
    check_eq("R9", "writes after abort", wr_cnt, 0);
    check_eq("R9", "reads after abort", int'(rd_cnt <= 4), 1);
  endtask

  initial begin
    int tl[9];
    int fl[3];
    tl = '{0, 1, 2, 3, 4, 5, 6, 9, 99};
    fl = '{0, 3, 99};
    rst_ni = 1'b0;
    start_i = 1'b0;
    abort_i = 1'b0;
    stat_addr_i = '0;
    exp_addr = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_eq("R1", "busy", int'(busy_o), 0);
    check_eq("R1", "req", int'(req_o), 0);
    check_eq("R1", "done", int'(done_o), 0);
    check_eq("R1", "fail", int'(fail_o), 0);
    check_eq("R1", "timeout", int'(timeout_o), 0);
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 9; c++)
          for (int d = 0; d < 3; d++)
            run_case(tl[a], fl[b], tl[c], fl[d], ((a + b + c + d) % 7) == 0);
    abort_case();
    run_case(0, 99, 1, 99, 1'b0); // R9 resume from a fresh pair
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule